// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Asynchronous and Clocked Modes

This block turns host words into a serial bit stream on `txd`. The host presents a word of up to nine bits and pulses `wr_stb`. The word lands in a holding register. When the line is free and the far end permits it (`cts_n` low), the word is copied into a shift register and sent. Because the holding register is emptied at the start of the frame, the host can queue the next word while the current one is still on the wire. Frames then follow each other with no idle time between them.

A three-bit mode code picks the frame shape. In the asynchronous modes a frame carries a start bit, 7, 8 or 9 data bits sent LSB first, an optional odd or even parity bit, and one or two stop bits. Each bit lasts sixteen pulses of the `bit_tick` enable. In clocked mode eight data bits are shifted out with no framing. The shift clock is either made from `bit_tick` and driven on `sclk_out`, or taken from the `sclk_in` pin. The frame shape is latched when a word enters the shift register, so changing the controls only affects later frames.

The controller is a state machine with states IDLE, START, DATA, PARITY, STOP and SYNC:
- IDLE→START or IDLE→SYNC when a word is taken.
- START→DATA at the end of the start bit.
- DATA→DATA after each data bit but the last. After the last data bit, DATA→PARITY if parity is on, otherwise DATA→STOP.
- PARITY→STOP.
- STOP→STOP after the first of two stop bits.
- SYNC→SYNC after each clocked bit but the eighth.
- STOP or SYNC→START or SYNC when the final bit ends and another word is ready (chained reload). Otherwise STOP or SYNC→IDLE.
- Any state→IDLE whenever the mode code is not a valid one.

Top module: `serial_tx_core`

## Requirements
- R1: The mode code 3'b000, and any code other than 001/100/101/110, holds `txd` high, keeps the state machine idle and leaves a queued word untaken (`buf_empty` stays 0).
- R2: Codes 100, 101 and 110 send asynchronous frames of 7, 8 and 9 data bits. The frame is a low start bit, then the low bits of the word LSB first.
- R3: With `parity_en`=1 a parity bit follows the data. It makes the count of ones in data plus parity odd when `parity_even`=0 and even when `parity_even`=1. With `parity_en`=0 no parity bit is sent.
- R4: After the data (and parity), `txd` is high for one stop bit when `two_stop`=0 and for two stop bits when `two_stop`=1.
- R5: Every asynchronous bit lasts exactly 16 `bit_tick` pulses, counted from the cycle after the word is taken.
- R6: Code 001 with `ext_clk_sel`=0 shifts 8 bits LSB first with no start, parity or stop bits. Each bit spans two `bit_tick` pulses: `sclk_out` is low for the first and high for the second, and `txd` holds the bit at the rising edge. `sclk_out` is high when no clocked transfer runs.
- R7: Code 001 with `ext_clk_sel`=1 presents bit 0 when the word is taken and moves to the next bit after each rising edge of `sclk_in`, which passes through a two-stage synchronizer. `sclk_out` stays high.
- R8: No word is taken while `cts_n` is high. A word waiting in the buffer starts once `cts_n` goes low.
- R9: `buf_empty` goes high in the cycle after the word is copied into the shift register. A word written during a frame is sent directly after that frame's last stop bit, with no idle time between the frames.
- R10: `tx_done` is high exactly when the state machine is idle and the buffer is empty. It is high after reset and low while a frame is sent or a word waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Mode code: 000 off, 001 clocked, 100/101/110 asynchronous 7/8/9 bits |
| ext_clk_sel | input | 1 | Clocked mode: 1 takes the shift clock from `sclk_in` |
| two_stop | input | 1 | 1 selects two stop bits |
| parity_even | input | 1 | 1 even parity, 0 odd parity |
| parity_en | input | 1 | 1 appends a parity bit |
| wr_stb | input | 1 | One-cycle write of `wr_data` into the holding register |
| wr_data | input | 9 | Word to send; low bits used in shorter modes |
| bit_tick | input | 1 | Bit-rate enable pulse |
| cts_n | input | 1 | Active-low clear-to-send |
| sclk_in | input | 1 | External shift clock for clocked mode |
| txd | output | 1 | Serial data, idle high |
| sclk_out | output | 1 | Internally made shift clock, idle high |
| buf_empty | output | 1 | Holding register can accept a word |
| tx_done | output | 1 | Nothing sent or pending |

## Verification
The hardest situation to reach is the chained reload: a new word has to arrive while the final stop bit is still on the line. The next frame's start bit must then follow with no gap, and the bit counter must restart cleanly. The bench decodes each frame by counting `bit_tick` pulses from the falling start edge. It writes the follow-up word from inside the middle of the last stop bit and counts the pulses between there and the next falling edge. That count must equal the remainder of the stop bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam logic [2:0] MODE_OFF  = 3'b000;
    localparam logic [2:0] MODE_SYNC = 3'b001;
    localparam logic [2:0] MODE_A7   = 3'b100;
    localparam logic [2:0] MODE_A8   = 3'b101;
    localparam logic [2:0] MODE_A9   = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_SYNC
    } tx_state_e;

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (wr_stb) begin
            word <= wr_data;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_stb) |=> !full); // R9
    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full); // R9

endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sync_mode,
    input  logic ext_clk,
    input  logic bit_tick,
    input  logic sclk_in,
    output logic bit_end,
    output logic sclk_low
);

    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             phase;
    logic [2:0]       sclk_sy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sy <= 3'b111;
        end else begin
            sclk_sy <= {sclk_sy[1:0], sclk_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            phase    <= 1'b0;
        end else if (restart) begin
            tick_cnt <= '0;
            phase    <= 1'b0;
        end else if (bit_tick) begin
            tick_cnt <= (tick_cnt == CNT_LAST) ? '0 : tick_cnt + 1'b1;
            phase    <= ~phase;
        end
    end

    always_comb begin
        if (sync_mode) begin
            if (ext_clk) begin
                bit_end = sclk_sy[1] & ~sclk_sy[2];
            end else begin
                bit_end = bit_tick & phase;
            end
        end else begin
            bit_end = bit_tick && (tick_cnt == CNT_LAST);
        end
    end

    assign sclk_low = ~phase;

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int WORD_W    = 9,
    parameter int SYNC_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic              ext_clk_sel,
    input  logic              two_stop,
    input  logic              parity_even,
    input  logic              parity_en,
    input  logic              cts_n,
    input  logic              buf_full,
    input  logic [WORD_W-1:0] buf_word,
    input  logic              bit_end,
    input  logic              sclk_low,
    output logic              take,
    output logic              txd,
    output logic              sclk_out,
    output logic              idle,
    output logic              cfg_sync,
    output logic              cfg_ext
);

    localparam int IDX_W = $clog2(WORD_W + 1);

    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  c_nbits;
    logic              c_par_en, c_two_stop, par_bit, stop2nd;
    logic              enabled, sync_live, can_load, last_data, par_live;
    logic              shift, adv_stop;
    logic [IDX_W-1:0]  nbits_live;
    logic [WORD_W-1:0] dmask;

    assign enabled   = mode_sel inside {MODE_SYNC, MODE_A7, MODE_A8, MODE_A9};
    assign sync_live = (mode_sel == MODE_SYNC);
    assign can_load  = enabled && buf_full && !cts_n;
    assign last_data = (bit_idx == c_nbits - 1'b1);

    always_comb begin
        case (mode_sel)
            MODE_A7: nbits_live = IDX_W'(7);
            MODE_A8: nbits_live = IDX_W'(8);
            MODE_A9: nbits_live = IDX_W'(9);
            default: nbits_live = IDX_W'(SYNC_BITS);
        endcase
        for (int i = 0; i < WORD_W; i++) begin
            dmask[i] = (i < int'(nbits_live));
        end
        par_live = (^(buf_word & dmask)) ^ ~parity_even;
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        shift    = 1'b0;
        adv_stop = 1'b0;
        if (!enabled) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (can_load) begin
                        take    = 1'b1;
                        state_d = sync_live ? ST_SYNC : ST_START;
                    end
                end
                ST_START: begin
                    if (bit_end) state_d = ST_DATA;
                end
                ST_DATA: begin
                    if (bit_end) begin
                        if (last_data) state_d = c_par_en ? ST_PARITY : ST_STOP;
                        else           shift   = 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (bit_end) state_d = ST_STOP;
                end
                ST_STOP: begin
                    if (bit_end) begin
                        if (c_two_stop && !stop2nd) begin
                            adv_stop = 1'b1;
                        end else if (can_load) begin
                            take    = 1'b1;
                            state_d = sync_live ? ST_SYNC : ST_START;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_SYNC: begin
                    if (bit_end) begin
                        if (!last_data) begin
                            shift = 1'b1;
                        end else if (can_load) begin
                            take    = 1'b1;
                            state_d = sync_live ? ST_SYNC : ST_START;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and latched frame shape
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_idx    <= '0;
            stop2nd    <= 1'b0;
            c_nbits    <= IDX_W'(SYNC_BITS);
            c_par_en   <= 1'b0;
            c_two_stop <= 1'b0;
            par_bit    <= 1'b0;
            cfg_sync   <= 1'b0;
            cfg_ext    <= 1'b0;
        end else if (take) begin
            shreg      <= buf_word;
            bit_idx    <= '0;
            stop2nd    <= 1'b0;
            c_nbits    <= nbits_live;
            c_par_en   <= parity_en & ~sync_live;
            c_two_stop <= two_stop;
            par_bit    <= par_live;
            cfg_sync   <= sync_live;
            cfg_ext    <= ext_clk_sel;
        end else begin
            if (shift) begin
                shreg   <= {1'b0, shreg[WORD_W-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
            if (adv_stop) stop2nd <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_bit;
            ST_STOP:   txd = 1'b1;
            ST_SYNC:   txd = shreg[0];
            default:   txd = 1'b1;
        endcase
        sclk_out = !((state_q == ST_SYNC) && !cfg_ext && sclk_low);
        idle     = (state_q == ST_IDLE);
    end

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> txd); // R1
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !sync_live) |=> !txd); // R2
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_DATA, ST_SYNC}) |-> (bit_idx < c_nbits)); // R2
    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !cts_n); // R8
    AST_SHIFT_ONLY_ON_BIT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_end && !take) |=> $stable(shreg)); // R7

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
    parameter int WORD_W    = 9,
    parameter int OVS       = 16,
    parameter int SYNC_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic              ext_clk_sel,
    input  logic              two_stop,
    input  logic              parity_even,
    input  logic              parity_en,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              bit_tick,
    input  logic              cts_n,
    input  logic              sclk_in,
    output logic              txd,
    output logic              sclk_out,
    output logic              buf_empty,
    output logic              tx_done
);

    logic              take, buf_full, bit_end, sclk_low, idle, cfg_sync, cfg_ext;
    logic [WORD_W-1:0] buf_word;

    sertx_holdbuf #(.WORD_W(WORD_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (buf_full),
        .word    (buf_word)
    );

    sertx_bitclk #(.OVS(OVS)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (take),
        .sync_mode (cfg_sync),
        .ext_clk   (cfg_ext),
        .bit_tick  (bit_tick),
        .sclk_in   (sclk_in),
        .bit_end   (bit_end),
        .sclk_low  (sclk_low)
    );

    sertx_fsm #(.WORD_W(WORD_W), .SYNC_BITS(SYNC_BITS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .ext_clk_sel (ext_clk_sel),
        .two_stop    (two_stop),
        .parity_even (parity_even),
        .parity_en   (parity_en),
        .cts_n       (cts_n),
        .buf_full    (buf_full),
        .buf_word    (buf_word),
        .bit_end     (bit_end),
        .sclk_low    (sclk_low),
        .take        (take),
        .txd         (txd),
        .sclk_out    (sclk_out),
        .idle        (idle),
        .cfg_sync    (cfg_sync),
        .cfg_ext     (cfg_ext)
    );

    assign buf_empty = ~buf_full;
    assign tx_done   = idle & ~buf_full;

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (txd && sclk_out)); // R10

endmodule

// File: tb/serial_tx_core_tb.sv
module serial_tx_core_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode_sel;
    logic       ext_clk_sel, two_stop, parity_even, parity_en;
    logic       wr_stb;
    logic [8:0] wr_data;
    logic       bit_tick;
    logic       cts_n, sclk_in;
    logic       txd, sclk_out, buf_empty, tx_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    serial_tx_core u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .ext_clk_sel (ext_clk_sel),
        .two_stop    (two_stop),
        .parity_even (parity_even),
        .parity_en   (parity_en),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .bit_tick    (bit_tick),
        .cts_n       (cts_n),
        .sclk_in     (sclk_in),
        .txd         (txd),
        .sclk_out    (sclk_out),
        .buf_empty   (buf_empty),
        .tx_done     (tx_done)
    );

    // bit-rate enable: one pulse every three clocks, changed away from the edge
    initial begin
        bit_tick = 1'b0;
        forever begin
            repeat (2) @(posedge clk);
            #1 bit_tick = 1'b1;
            @(posedge clk);
            #1 bit_tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        finish_run();
    end

    function automatic logic [12:0] frame_bits(input int nb, input bit pe, input bit pev,
                                               input bit ts, input logic [8:0] d);
        logic [12:0] v;
        int          pos;
        logic        ones;
        v    = '1;
        v[0] = 1'b0;
        ones = 1'b0;
        for (int i = 0; i < nb; i++) begin
            v[1+i] = d[i];
            ones   = ones ^ d[i];
        end
        pos = 1 + nb;
        if (pe) begin
            v[pos] = pev ? ones : ~ones;
            pos++;
        end
        v[pos] = 1'b1;
        if (ts) v[pos+1] = 1'b1;
        return v;
    endfunction

    task automatic write_word(input logic [8:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic recv_async(input int nb, input bit pe, input bit pev, input bit ts,
                              input logic [8:0] d);
        logic [12:0] e, ga, gc;
        int          len, k, b, msk, sp;
        len = 2 + nb + int'(pe) + int'(ts);
        e   = frame_bits(nb, pe, pev, ts, d);
        ga  = '0;
        gc  = '0;
        while (txd !== 1'b0) @(negedge clk);
        k = 0;
        b = 0;
        while (b < len) begin
            if (bit_tick) begin
                k++;
                if (k == 16*b + 3) ga[b] = txd;
                if (k == 16*b + 13) begin
                    gc[b] = txd;
                    b++;
                end
            end
            if (b < len) @(negedge clk);
        end
        msk = (1 << (nb + 1)) - 1;
        chk((int'(ga) & msk) == (int'(e) & msk), "R2", "start+data bits",
            int'(ga) & msk, int'(e) & msk);
        if (pe) chk(ga[nb+1] == e[nb+1], "R3", "parity bit", ga[nb+1], e[nb+1]);
        sp = nb + 1 + int'(pe);
        chk(ga[sp] == 1'b1 && (!ts || ga[sp+1] == 1'b1), "R4", "stop bits",
            int'(ga) >> sp, ts ? 3 : 1);
        chk((ga ^ gc) == '0, "R5", "bit held for 16 ticks", int'(gc), int'(ga));
    endtask

    // counts ticks from mid last stop bit to the next falling edge, writing d meanwhile
    task automatic gap_write(input logic [8:0] d, output int g);
        int n;
        g = 0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                wr_stb  = 1'b1;
                wr_data = d;
            end else if (n == 2) begin
                wr_stb = 1'b0;
            end
            if (txd === 1'b0) break;
            if (bit_tick) g++;
        end
    endtask

    task automatic wait_done();
        while (tx_done !== 1'b1) @(negedge clk);
    endtask

    task automatic recv_sync_int(input logic [7:0] d);
        logic [7:0] got;
        int         rises;
        logic       prev;
        rises = 0;
        prev  = sclk_out;
        got   = '0;
        while (rises < 8) begin
            @(negedge clk);
            if (!prev && sclk_out) begin
                got[rises] = txd;
                rises++;
            end
            prev = sclk_out;
        end
        chk(got == d, "R6", "clocked internal bits", got, d);
        repeat (12) @(negedge clk);
        chk(sclk_out == 1'b1 && tx_done == 1'b1, "R6", "shift clock idle high",
            {sclk_out, tx_done}, 3);
    endtask

    task automatic send_sync_ext(input logic [7:0] d);
        logic [7:0] got;
        bit         sclk_seen_low;
        sclk_seen_low = 1'b0;
        write_word({1'b0, d});
        repeat (4) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            sclk_in = 1'b0;
            repeat (6) begin
                @(negedge clk);
                if (!sclk_out) sclk_seen_low = 1'b1;
            end
            got[b]  = txd;
            sclk_in = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (!sclk_out) sclk_seen_low = 1'b1;
            end
        end
        chk(got == d, "R7", "clocked external bits", got, d);
        chk(!sclk_seen_low, "R7", "sclk_out stays high", sclk_seen_low, 0);
        chk(tx_done == 1'b1, "R7", "done after eight edges", tx_done, 1);
    endtask

    initial begin
        logic [8:0]  d;
        int          g;
        bit          txd_dropped;
        int unsigned seed_init;

        seed_init   = $urandom(32'd715);
        rst_n       = 1'b0;
        mode_sel    = 3'b000;
        ext_clk_sel = 1'b0;
        two_stop    = 1'b0;
        parity_even = 1'b0;
        parity_en   = 1'b0;
        wr_stb      = 1'b0;
        wr_data     = '0;
        cts_n       = 1'b0;
        sclk_in     = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk(txd == 1'b1 && sclk_out == 1'b1, "R1", "reset line state", {txd, sclk_out}, 3);
        chk(buf_empty == 1'b1 && tx_done == 1'b1, "R10", "reset flags", {buf_empty, tx_done}, 3);

        // R1: disabled codes hold the line and leave the word queued
        write_word(9'h055);
        txd_dropped = 1'b0;
        repeat (60) begin
            @(negedge clk);
            if (!txd) txd_dropped = 1'b1;
        end
        mode_sel = 3'b011;
        repeat (60) begin
            @(negedge clk);
            if (!txd) txd_dropped = 1'b1;
        end
        chk(!txd_dropped, "R1", "txd high while off", txd_dropped, 0);
        chk(buf_empty == 1'b0, "R1", "word not taken while off", buf_empty, 0);
        chk(tx_done == 1'b0, "R10", "done low with word pending", tx_done, 0);
        mode_sel = 3'b101;
        recv_async(8, 1'b0, 1'b0, 1'b0, 9'h055);
        wait_done();

        // R8: clear-to-send gating
        @(negedge clk);
        cts_n = 1'b1;
        write_word(9'h0A3);
        txd_dropped = 1'b0;
        repeat (150) begin
            @(negedge clk);
            if (!txd) txd_dropped = 1'b1;
        end
        chk(!txd_dropped && buf_empty == 1'b0, "R8", "held while cts_n high",
            {txd_dropped, buf_empty}, 0);
        cts_n = 1'b0;
        recv_async(8, 1'b0, 1'b0, 1'b0, 9'h0A3);
        wait_done();

        // R9: double buffering and chained frames, two stop bits with even parity
        @(negedge clk);
        mode_sel    = 3'b110;
        parity_en   = 1'b1;
        parity_even = 1'b1;
        two_stop    = 1'b1;
        write_word(9'h1C5);
        @(negedge clk);
        chk(buf_empty == 1'b1 && txd == 1'b0, "R9", "empty once frame starts",
            {buf_empty, txd}, 2);
        chk(tx_done == 1'b0, "R10", "done low during frame", tx_done, 0);
        recv_async(9, 1'b1, 1'b1, 1'b1, 9'h1C5);
        gap_write(9'h03A, g);
        chk(g == 3, "R9", "no idle gap between chained frames", g, 3);
        recv_async(9, 1'b1, 1'b1, 1'b1, 9'h03A);
        chk(tx_done == 1'b0, "R10", "done low in last stop bit", tx_done, 0);
        repeat (40) @(negedge clk);
        chk(tx_done == 1'b1 && buf_empty == 1'b1, "R10", "done after last frame",
            {tx_done, buf_empty}, 3);

        // directed corners: all ones and all zeros with odd parity, 7 and 9 bits
        @(negedge clk);
        mode_sel = 3'b100; parity_en = 1'b1; parity_even = 1'b0; two_stop = 1'b0;
        write_word(9'h1FF);
        recv_async(7, 1'b1, 1'b0, 1'b0, 9'h1FF);
        wait_done();
        @(negedge clk);
        mode_sel = 3'b110;
        write_word(9'h000);
        recv_async(9, 1'b1, 1'b0, 1'b0, 9'h000);
        wait_done();

        // random asynchronous frames
        for (int it = 0; it < 24; it++) begin
            int m;
            m = int'($urandom_range(2, 0));
            @(negedge clk);
            mode_sel    = (m == 0) ? 3'b100 : (m == 1) ? 3'b101 : 3'b110;
            parity_en   = 1'($urandom_range(1, 0));
            parity_even = 1'($urandom_range(1, 0));
            two_stop    = 1'($urandom_range(1, 0));
            d           = 9'($urandom_range(511, 0));
            write_word(d);
            recv_async(7 + m, parity_en, parity_even, two_stop, d);
            wait_done();
        end

        // R6: clocked mode, internal shift clock
        for (int it = 0; it < 3; it++) begin
            @(negedge clk);
            mode_sel    = 3'b001;
            ext_clk_sel = 1'b0;
            d           = 9'($urandom_range(511, 0));
            write_word(d);
            recv_sync_int(d[7:0]);
        end
        @(negedge clk);
        write_word(9'h001);
        recv_sync_int(8'h01);

        // R7: clocked mode, external shift clock
        @(negedge clk);
        ext_clk_sel = 1'b1;
        send_sync_ext(8'hB6);
        send_sync_ext(8'($urandom_range(255, 0)) | 8'h80);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule